// File: doc/BRIEF.md
# Multi-Memory March Self-Test Controller

This block runs a March-type self-test over a small set of on-chip memories that differ in depth and in data width. One start pulse walks every attached memory in index order, and each memory gets the full algorithm before the next one begins. When the last memory is finished, the block raises a done level. It also presents one sticky pass/fail bit per memory.

The work is split across two state machines. The outer sequencer chooses the memory under test and marks it active. The inner algorithm machine steps through six March elements and through the read and write operations inside each one. One shared address counter serves every memory. It counts up or down, loads its end value from the active memory's depth, and reports when a sweep reaches its last address. A port stage sits between the counter and the memories. It masks the address and the data background down to the active memory's size, and it routes the write and read strobes to that memory alone. Read data comes back one cycle after the read strobe and is compared then.

The element list is {any(w0); down(r0,w1); up(r1,w0,r0,r0,w1); up(r1,w0); up(r0,w1,r1,r1,w0); up(r0)}. Each address therefore receives 7 writes and 9 reads.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, done_o is 0, every fail_o bit is 0, and all write and read strobes are 0.
- R2: Memories are tested one at a time in ascending index order. At most one memory has a write or read strobe high in any cycle.
- R3: During one run, each memory of depth D = 2^AW receives exactly 7*D write strobes and exactly 9*D read strobes.
- R4: The address sent to a memory with address width AW has every bit at position AW or above equal to 0, so it never exceeds D-1.
- R5: Write data is all zeros or all ones over the memory's low DW bits. Every bit at position DW or above is 0.
- R6: Read data is compared one cycle after its read strobe against the expected background over the low DW bits. A mismatch sets the fail bit of the memory that was read, and of no other memory.
- R7: Read-data bits at position DW or above have no effect on the fail bits.
- R8: done_o rises only after the last memory completes its final element. done_o and fail_o then stay constant until the next start_i, and a new start clears all fail bits.
- R9: Whenever the test is not running, including the time while done_o is high, every write and read strobe is 0.
- R10: For each memory, the first write goes to address 0, because the first element ascends. The first read goes to address D-1, because the second element descends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| done_o | output | 1 | High from the end of a run until the next start |
| fail_o | output | NUM_MEM | Sticky fail bit per memory |
| mem_addr_o | output | NUM_MEM*MAX_AW | Address per memory, MAX_AW-bit slices |
| mem_wdata_o | output | NUM_MEM*MAX_DW | Write data per memory, MAX_DW-bit slices |
| mem_we_o | output | NUM_MEM | Write strobe per memory |
| mem_re_o | output | NUM_MEM | Read strobe per memory |
| mem_rdata_i | input | NUM_MEM*MAX_DW | Read data per memory, valid one cycle after its read strobe |

## Verification
The hardest cases to reach from the ports are two faults that only show up in a single read. One is a single stuck data bit at the last address of a descending sweep. The other is a stuck bit that lies above a narrow memory's data width, which must be ignored. The bench's memory models inject a chosen stuck-at value on one bit of one address, and always return all ones in the unused upper data bits. A table of such faults is walked run after run. Each run checks which fail bits are set and that fail bits from the previous run were cleared. A port monitor tallies strobe counts, address order and bus masking for every memory.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int unsigned NUM_ELEM = 6;
  localparam int unsigned ELEM_W   = 3;
  localparam int unsigned OPI_W    = 3;

  typedef struct packed {
    logic wr;   // 1 = write, 0 = read
    logic val;  // background bit
  } mop_t;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_LAUNCH, SEQ_WAIT, SEQ_FLUSH, SEQ_DONE
  } seq_state_e;

  localparam mop_t OP_W0 = '{wr: 1'b1, val: 1'b0};
  localparam mop_t OP_W1 = '{wr: 1'b1, val: 1'b1};
  localparam mop_t OP_R0 = '{wr: 1'b0, val: 1'b0};
  localparam mop_t OP_R1 = '{wr: 1'b0, val: 1'b1};

  function automatic logic [OPI_W-1:0] elem_ops(input logic [ELEM_W-1:0] e);
    case (e)
      3'd0, 3'd5: return 3'd1;
      3'd2, 3'd4: return 3'd5;
      default:    return 3'd2;
    endcase
  endfunction

  function automatic logic elem_desc(input logic [ELEM_W-1:0] e);
    return e == 3'd1;
  endfunction

  // {element, op index} in octal digits
  function automatic mop_t elem_op(input logic [ELEM_W-1:0] e, input logic [OPI_W-1:0] o);
    case ({e, o})
      6'o00: return OP_W0;
      6'o10: return OP_R0;
      6'o11: return OP_W1;
      6'o20: return OP_R1;
      6'o21: return OP_W0;
      6'o22: return OP_R0;
      6'o23: return OP_R0;
      6'o24: return OP_W1;
      6'o30: return OP_R1;
      6'o31: return OP_W0;
      6'o40: return OP_R0;
      6'o41: return OP_W1;
      6'o42: return OP_R1;
      6'o43: return OP_R1;
      6'o44: return OP_W0;
      6'o50: return OP_R0;
      default: return OP_R0;
    endcase
  endfunction
endpackage

// File: rtl/mbist_addr_cnt.sv
module mbist_addr_cnt #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          desc_i,
  input  logic          step_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic          desc_q;
  logic [AW-1:0] cnt_q;

  assign addr_o = cnt_q;
  assign last_o = desc_q ? (cnt_q == '0) : (cnt_q == end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      desc_q <= desc_i;
      cnt_q  <= desc_i ? end_i : '0;
    end else if (step_i) begin
      cnt_q <= desc_q ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q <= end_i);
  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
endmodule

// File: rtl/mbist_alg_fsm.sv
module mbist_alg_fsm
  import mbist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic addr_last_i,
  output logic active_o,
  output mop_t op_o,
  output logic load_o,
  output logic load_desc_o,
  output logic step_o,
  output logic done_o
);
  logic              active_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPI_W-1:0]  opi_q;
  logic              op_last, elem_last, sweep_end;

  assign op_last     = opi_q == elem_ops(elem_q) - 3'd1;
  assign elem_last   = elem_q == ELEM_W'(NUM_ELEM - 1);
  assign sweep_end   = active_q & op_last & addr_last_i;
  assign done_o      = sweep_end & elem_last;
  assign load_o      = start_i | (sweep_end & ~elem_last);
  assign load_desc_o = start_i ? elem_desc('0) : elem_desc(elem_q + 1'b1);
  assign step_o      = active_q & op_last & ~addr_last_i;
  assign op_o        = elem_op(elem_q, opi_q);
  assign active_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      elem_q   <= '0;
      opi_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      elem_q   <= '0;
      opi_q    <= '0;
    end else if (active_q) begin
      if (op_last) begin
        opi_q <= '0;
        if (addr_last_i) begin
          if (elem_last) active_q <= 1'b0;
          else           elem_q   <= elem_q + 1'b1;
        end
      end else begin
        opi_q <= opi_q + 1'b1;
      end
    end
  end

  assert_opi_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> opi_q < elem_ops(elem_q));
  assert_done_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !active_o);
endmodule

// File: rtl/mbist_mem_seq.sv
module mbist_mem_seq
  import mbist_pkg::*;
#(
  parameter int unsigned NUM_MEM = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             alg_done_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             launch_o,
  output logic             clear_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [SEL_W-1:0] sel_q;
  logic             accept;

  assign accept   = start_i & ((state_q == SEQ_IDLE) | (state_q == SEQ_DONE));
  assign clear_o  = accept;
  assign launch_o = state_q == SEQ_LAUNCH;
  assign done_o   = state_q == SEQ_DONE;
  assign sel_o    = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      sel_q   <= '0;
    end else if (accept) begin
      state_q <= SEQ_LAUNCH;
      sel_q   <= '0;
    end else begin
      case (state_q)
        SEQ_LAUNCH: state_q <= SEQ_WAIT;
        SEQ_WAIT:   if (alg_done_i) state_q <= SEQ_FLUSH;
        SEQ_FLUSH: begin
          // one slack cycle lets the final read compare land
          if (sel_q == SEL_W'(NUM_MEM - 1)) state_q <= SEQ_DONE;
          else begin
            sel_q   <= sel_q + 1'b1;
            state_q <= SEQ_LAUNCH;
          end
        end
        default: ;
      endcase
    end
  end

  assert_sel_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q < SEL_W'(NUM_MEM));
  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/mbist_port_ctrl.sv
module mbist_port_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned NUM_MEM   = 3,
  parameter int unsigned MAX_AW    = 4,
  parameter int unsigned MAX_DW    = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned MEM_AW[4] = '{3, 4, 2, 1},
  parameter int unsigned MEM_DW[4] = '{8, 4, 6, 1}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      run_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  mop_t                      op_i,
  input  logic [MAX_AW-1:0]         addr_i,
  output logic [NUM_MEM*MAX_AW-1:0] mem_addr_o,
  output logic [NUM_MEM*MAX_DW-1:0] mem_wdata_o,
  output logic [NUM_MEM-1:0]        mem_we_o,
  output logic [NUM_MEM-1:0]        mem_re_o,
  input  logic [NUM_MEM*MAX_DW-1:0] mem_rdata_i,
  output logic [NUM_MEM-1:0]        fail_o
);
  logic             rd_pend_q, rd_exp_q;
  logic [SEL_W-1:0] rd_sel_q;
  logic [NUM_MEM-1:0] fail_q, miss;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_port
    localparam logic [MAX_AW-1:0] AMASK = MAX_AW'((64'd1 << MEM_AW[m]) - 64'd1);
    localparam logic [MAX_DW-1:0] DMASK = MAX_DW'((64'd1 << MEM_DW[m]) - 64'd1);
    logic hit;
    logic [MAX_DW-1:0] diff;

    assign hit = run_i & (sel_i == SEL_W'(m));
    assign mem_addr_o[m*MAX_AW +: MAX_AW]  = hit ? (addr_i & AMASK) : '0;
    assign mem_wdata_o[m*MAX_DW +: MAX_DW] = hit ? ({MAX_DW{op_i.val}} & DMASK) : '0;
    assign mem_we_o[m] = hit & op_i.wr;
    assign mem_re_o[m] = hit & ~op_i.wr;
    assign diff    = (mem_rdata_i[m*MAX_DW +: MAX_DW] ^ {MAX_DW{rd_exp_q}}) & DMASK;
    assign miss[m] = rd_pend_q & (rd_sel_q == SEL_W'(m)) & (|diff);
  end

  assign fail_o = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_exp_q  <= 1'b0;
      rd_sel_q  <= '0;
      fail_q    <= '0;
    end else begin
      rd_pend_q <= |mem_re_o;
      rd_exp_q  <= op_i.val;
      rd_sel_q  <= sel_i;
      fail_q    <= clear_i ? '0 : (fail_q | miss);
    end
  end

  assert_single_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_we_o | mem_re_o));
  assert_fail_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
  assert_fail_needs_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !rd_pend_q) |=> $stable(fail_q));
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned NUM_MEM   = 3,
  parameter int unsigned MAX_AW    = 4,
  parameter int unsigned MAX_DW    = 8,
  parameter int unsigned MEM_AW[4] = '{3, 4, 2, 1},
  parameter int unsigned MEM_DW[4] = '{8, 4, 6, 1}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      done_o,
  output logic [NUM_MEM-1:0]        fail_o,
  output logic [NUM_MEM*MAX_AW-1:0] mem_addr_o,
  output logic [NUM_MEM*MAX_DW-1:0] mem_wdata_o,
  output logic [NUM_MEM-1:0]        mem_we_o,
  output logic [NUM_MEM-1:0]        mem_re_o,
  input  logic [NUM_MEM*MAX_DW-1:0] mem_rdata_i
);
  localparam int unsigned SEL_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;

  logic [SEL_W-1:0]  sel;
  logic              launch, clear, alg_done, run;
  logic              load, load_desc, step, addr_last;
  logic [MAX_AW-1:0] addr, end_val;
  logic [MAX_AW-1:0] end_tab [NUM_MEM];
  mop_t              op;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_end
    assign end_tab[m] = MAX_AW'((64'd1 << MEM_AW[m]) - 64'd1);
  end
  assign end_val = end_tab[sel];

  mbist_mem_seq #(.NUM_MEM(NUM_MEM), .SEL_W(SEL_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .alg_done_i(alg_done), .sel_o(sel), .launch_o(launch),
    .clear_o(clear), .done_o(done_o)
  );

  mbist_alg_fsm u_alg (
    .clk_i, .rst_ni, .start_i(launch), .addr_last_i(addr_last),
    .active_o(run), .op_o(op), .load_o(load), .load_desc_o(load_desc),
    .step_o(step), .done_o(alg_done)
  );

  mbist_addr_cnt #(.AW(MAX_AW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .desc_i(load_desc), .step_i(step),
    .end_i(end_val), .addr_o(addr), .last_o(addr_last)
  );

  mbist_port_ctrl #(
    .NUM_MEM(NUM_MEM), .MAX_AW(MAX_AW), .MAX_DW(MAX_DW), .SEL_W(SEL_W),
    .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
  ) u_port (
    .clk_i, .rst_ni, .clear_i(clear), .run_i(run), .sel_i(sel), .op_i(op),
    .addr_i(addr), .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_re_o,
    .mem_rdata_i, .fail_o
  );

  assert_quiet_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((mem_we_o | mem_re_o) == '0));
  assert_fail_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(fail_o));
endmodule

// File: tb/mbist_ctrl_tb.sv
module mbist_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int AWM = 4;
  localparam int DWM = 8;
  localparam int unsigned TB_AW[4] = '{3, 4, 2, 1};
  localparam int unsigned TB_DW[4] = '{8, 4, 6, 1};

  typedef struct packed {
    logic       en;
    logic [1:0] mem;
    logic [3:0] addr;
    logic [2:0] bitp;
    logic       sval;
    logic [2:0] exp_fail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC[NV] = '{
    '{1'b0, 2'd0, 4'd0,  3'd0, 1'b0, 3'b000},
    '{1'b1, 2'd0, 4'd5,  3'd7, 1'b0, 3'b001},
    '{1'b1, 2'd1, 4'd15, 3'd2, 1'b1, 3'b010},
    '{1'b1, 2'd1, 4'd3,  3'd6, 1'b0, 3'b000},  // bit above width: ignored (R7)
    '{1'b1, 2'd2, 4'd0,  3'd5, 1'b0, 3'b100},
    '{1'b1, 2'd2, 4'd3,  3'd0, 1'b1, 3'b100},
    '{1'b0, 2'd0, 4'd0,  3'd0, 1'b0, 3'b000}   // clears prior fail (R8)
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done;
  logic [NM-1:0] fail, we, re;
  logic [NM*AWM-1:0] addr;
  logic [NM*DWM-1:0] wdata, rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_ctrl #(.NUM_MEM(NM), .MAX_AW(AWM), .MAX_DW(DWM), .MEM_AW(TB_AW), .MEM_DW(TB_DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .fail_o(fail),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
    .mem_rdata_i(rdata)
  );

  // memory models with optional stuck-at bit on read, junk in unused upper bits
  logic [DWM-1:0] mem_arr [NM][16];
  logic f_en = 1'b0, f_val = 1'b0;
  int   f_mem = 0, f_addr = 0, f_bit = 0;

  always_ff @(posedge clk) begin
    for (int m = 0; m < NM; m++) begin
      logic [DWM-1:0] d;
      logic [3:0] a;
      a = addr[m*AWM +: 4];
      if (we[m]) mem_arr[m][a] <= wdata[m*DWM +: DWM];
      if (re[m]) begin
        d = mem_arr[m][a];
        if (f_en && f_mem == m && f_addr == int'(a)) d[f_bit] = f_val;
        d = d | ~DWM'((1 << TB_DW[m]) - 1);
        rdata[m*DWM +: DWM] <= d;
      end
    end
  end

  // port monitor
  int checks = 0, failures = 0, cyc = 0;
  logic mon_on = 1'b0;
  int wcnt[NM], rcnt[NM], first_w[NM], first_r[NM], first_c[NM], last_c[NM];
  int err_r2 = 0, err_r4 = 0, err_r5 = 0, err_r9 = 0;

  task automatic mon_clear();
    for (int m = 0; m < NM; m++) begin
      wcnt[m] = 0; rcnt[m] = 0; first_w[m] = -1; first_r[m] = -1;
      first_c[m] = -1; last_c[m] = -1;
    end
    err_r2 = 0; err_r4 = 0; err_r5 = 0; err_r9 = 0;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_on) begin
      if ($countones(we | re) > 1) err_r2++;
      if (done && (we | re) != '0) err_r9++;
      for (int m = 0; m < NM; m++) begin
        if (we[m] || re[m]) begin
          if (first_c[m] < 0) first_c[m] = cyc;
          last_c[m] = cyc;
          if ((addr[m*AWM +: AWM] >> TB_AW[m]) != 0) err_r4++;
        end
        if (we[m]) begin
          if (first_w[m] < 0) first_w[m] = int'(addr[m*AWM +: AWM]);
          wcnt[m]++;
          if ((wdata[m*DWM +: DWM] >> TB_DW[m]) != 0) err_r5++;
          if (wdata[m*DWM +: DWM] != 0 &&
              wdata[m*DWM +: DWM] != DWM'((1 << TB_DW[m]) - 1)) err_r5++;
        end
        if (re[m]) begin
          if (first_r[m] < 0 && first_w[m] >= 0) first_r[m] = int'(addr[m*AWM +: AWM]);
          rcnt[m]++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    if (!done) chk(1'b0, "watchdog R8", 0, 1);
  endtask

  initial begin
    for (int m = 0; m < NM; m++) rdata[m*DWM +: DWM] = '0;
    mon_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(fail == '0, "R1 fail", int'(fail), 0);
    chk((we | re) == '0, "R1 strobes", int'(we | re), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      f_en = VEC[v].en; f_mem = int'(VEC[v].mem); f_addr = int'(VEC[v].addr);
      f_bit = int'(VEC[v].bitp); f_val = VEC[v].sval;
      mon_clear();
      pulse_start();
      wait_done();
      @(negedge clk);
      chk(done, "R8 done", int'(done), 1);
      if (v == 3) chk(fail == VEC[v].exp_fail, "R7 upper bits ignored", int'(fail), int'(VEC[v].exp_fail));
      else        chk(fail == VEC[v].exp_fail, "R6 fail mask", int'(fail), int'(VEC[v].exp_fail));
      for (int m = 0; m < NM; m++) begin
        int dep;
        dep = 1 << TB_AW[m];
        chk(wcnt[m] == 7*dep, "R3 writes", wcnt[m], 7*dep);
        chk(rcnt[m] == 9*dep, "R3 reads", rcnt[m], 9*dep);
        chk(first_w[m] == 0, "R10 first write addr", first_w[m], 0);
        chk(first_r[m] == dep-1, "R10 first read addr", first_r[m], dep-1);
        if (m > 0) chk(last_c[m-1] < first_c[m], "R2 order", first_c[m], last_c[m-1]+1);
      end
      chk(err_r2 == 0, "R2 overlap", err_r2, 0);
      chk(err_r4 == 0, "R4 address bits", err_r4, 0);
      chk(err_r5 == 0, "R5 write data", err_r5, 0);
    end

    // R8/R9: idle after done, fail frozen; then one faulted run kept frozen
    f_en = 1'b1; f_mem = 0; f_addr = 7; f_bit = 3; f_val = 1'b1;
    mon_clear();
    pulse_start();
    wait_done();
    begin
      logic [NM-1:0] snap;
      snap = fail;
      f_en = 1'b0;
      repeat (20) @(negedge clk);
      chk(fail == snap, "R8 fail held", int'(fail), int'(snap));
      chk(snap == 3'b001, "R6 fault at top addr", int'(snap), 1);
      chk(done, "R8 done held", int'(done), 1);
      chk(err_r9 == 0, "R9 strobes while done", err_r9, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule